// File: doc/BRIEF.md
# System register access router

The block sits between instruction decode and the system register file of one core. For each system-register move request it matches the encoding against one register, the trace filter control register, and its alias encoding. It then applies an ordered set of trap and redirect rules and reports a single outcome one cycle later. The rules depend on the current exception level, on which higher levels exist, on whether those levels run the 32-bit or the 64-bit execution state, on the trace trap controls, on the nested-virtualisation controls and on the host-extension control.

The outcome is one of five: the level-1 register copy is accessed, the level-2 copy is accessed, the access is redirected to memory at a fixed offset, a trap is raised with a target level and a syndrome class, or the access is undefined. The block holds the level-1 copy itself. It stores only the timestamp-select field and the two trace-enable bits, and it returns read data for level-1 reads. Memory, the level-2 copy and exception entry are handled elsewhere.

Top module: `sysreg_access_router`

## Requirements
- R1: A request is recognised only for the primary encoding (op0=2'b11, op1=3'b000, CRn=4'b0001, CRm=4'b0010, op2=3'b001) or the alias encoding (the same with op1=3'b101). Any other request leaves valid_o low in the following cycle.
- R2: A recognised request at exception level 0 (cur_el_i=2'd0) is undefined.
- R3: For the primary encoding at level 1, the rules apply in this order. First, a trap to level 2 when level 2 is enabled, uses 64-bit state and has its trace trap set. Next, a trap to level 3 when level 3 exists, uses 64-bit state and has its trace trap set. Next, a memory redirect when level 2 is enabled, uses 64-bit state and nv_ctrl_i={NV2,NV1,NV}=3'b111. Otherwise the access goes to the level-1 copy.
- R4: For the primary encoding at level 2, an active level-3 trap (level 3 exists, uses 64-bit state, trap set) wins. Otherwise host_ext_i=1 gives a level-2 copy access and host_ext_i=0 gives a level-1 copy access.
- R5: For the primary encoding at level 3, the access always reaches the level-1 copy.
- R6: For the alias encoding at level 1 with level 2 enabled, nv_ctrl_i=3'b101 redirects to memory. Otherwise, if nv_ctrl_i[0]=1, the access traps to level 2. In every other level-1 case the access is undefined.
- R7: For the alias encoding with level 2 enabled and host_ext_i=1, an access at level 2 traps to level 3 when the level-3 trap is active and otherwise reaches the level-1 copy. An access at level 3 reaches the level-1 copy. Without level 2 enabled and host_ext_i=1, an alias access at level 2 or 3 is undefined.
- R8: A trap reports syndrome_o=6'h18 and trap_el_o=2 or 3 for its target level. A redirect reports mem_off_o=12'h880.
- R9: After reset the level-1 copy reads as zero. A level-1 write stores only bits [6:5] and [1:0] of wdata_i. A level-1 read returns those bits with all other bits zero. Any other outcome leaves the copy unchanged and drives rdata_o to zero.
- R10: In the cycle after a recognised request, valid_o is high and exactly one of acc_el1_o, acc_el2_o, mem_redir_o, trap_o, undef_o is high. All five are low when valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 64 | Write data |
| cur_el_i | input | 2 | Current exception level |
| el2_en_i | input | 1 | Level 2 enabled in the current security state |
| el3_has_i | input | 1 | Level 3 implemented |
| el2_a32_i | input | 1 | Level 2 uses 32-bit state |
| el3_a32_i | input | 1 | Level 3 uses 32-bit state |
| el2_trap_i | input | 1 | Level-2 trace register trap control |
| el3_trap_i | input | 1 | Level-3 trace register trap control |
| nv_ctrl_i | input | 3 | Nested-virtualisation controls {NV2,NV1,NV} |
| host_ext_i | input | 1 | Host-extension control |
| valid_o | output | 1 | Outcome valid |
| acc_el1_o | output | 1 | Access to level-1 copy |
| acc_el2_o | output | 1 | Access to level-2 copy |
| mem_redir_o | output | 1 | Redirect to memory |
| trap_o | output | 1 | Trap raised |
| undef_o | output | 1 | Undefined access |
| trap_el_o | output | 2 | Trap target level |
| syndrome_o | output | 6 | Trap syndrome class |
| mem_off_o | output | 12 | Redirect memory offset |
| rdata_o | output | 64 | Read data from level-1 copy |

## Verification
The hardest outcomes to reach are the deep alternatives of the priority chains. One example is the level-1 primary redirect, which needs both traps inactive while level 2 is enabled and in 64-bit state with all three nested controls set. Another is the alias redirect pattern 3'b101 set apart from the nearby NV=1 trap. Uniform random controls seldom line up this way, so the stimulus biases each control flag toward the value that opens the next rule. Directed requests cover each chain position and each masked write.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int unsigned DW = 64;
  localparam logic [1:0]  ENC_OP0   = 2'b11;
  localparam logic [2:0]  ENC_OP1   = 3'b000;
  localparam logic [2:0]  ENC_OP1_A = 3'b101;
  localparam logic [3:0]  ENC_CRN   = 4'b0001;
  localparam logic [3:0]  ENC_CRM   = 4'b0010;
  localparam logic [2:0]  ENC_OP2   = 3'b001;
  localparam logic [5:0]  SYN_CLASS = 6'h18;
  localparam logic [11:0] MEM_OFF   = 12'h880;
  localparam logic [DW-1:0] KEEP_MASK = 64'h63;

  typedef enum logic [2:0] {
    OC_EL1, OC_EL2, OC_MEM, OC_TRAP, OC_UNDEF
  } oc_e;
endpackage

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
(
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic [1:0] cur_el_i,
  input  logic       el2_en_i,
  input  logic       el3_has_i,
  input  logic       el2_a32_i,
  input  logic       el3_a32_i,
  input  logic       el2_trap_i,
  input  logic       el3_trap_i,
  input  logic [2:0] nv_ctrl_i,
  input  logic       host_ext_i,
  output logic       hit_o,
  output oc_e        oc_o,
  output logic [1:0] trap_el_o
);
  logic common, is_pri, is_ali, t2, t3, nv_all;

  assign common = (op0_i == ENC_OP0) && (crn_i == ENC_CRN) &&
                  (crm_i == ENC_CRM) && (op2_i == ENC_OP2);
  assign is_pri = common && (op1_i == ENC_OP1);
  assign is_ali = common && (op1_i == ENC_OP1_A);
  assign hit_o  = is_pri || is_ali;

  assign t2     = el2_en_i && !el2_a32_i && el2_trap_i;
  assign t3     = el3_has_i && !el3_a32_i && el3_trap_i;
  assign nv_all = el2_en_i && !el2_a32_i && (nv_ctrl_i == 3'b111);

  always_comb begin
    oc_o      = OC_UNDEF;
    trap_el_o = 2'd0;
    if (cur_el_i == 2'd0) begin
      oc_o = OC_UNDEF;
    end else if (is_pri) begin
      unique case (cur_el_i)
        2'd1: begin
          if (t2)          begin oc_o = OC_TRAP; trap_el_o = 2'd2; end
          else if (t3)     begin oc_o = OC_TRAP; trap_el_o = 2'd3; end
          else if (nv_all) oc_o = OC_MEM;
          else             oc_o = OC_EL1;
        end
        2'd2: begin
          if (t3)              begin oc_o = OC_TRAP; trap_el_o = 2'd3; end
          else if (host_ext_i) oc_o = OC_EL2;
          else                 oc_o = OC_EL1;
        end
        default: oc_o = OC_EL1;
      endcase
    end else if (cur_el_i == 2'd1) begin
      // alias at level 1
      if (el2_en_i && nv_ctrl_i == 3'b101)  oc_o = OC_MEM;
      else if (el2_en_i && nv_ctrl_i[0])   begin oc_o = OC_TRAP; trap_el_o = 2'd2; end
      else                                 oc_o = OC_UNDEF;
    end else if (el2_en_i && host_ext_i) begin
      if (cur_el_i == 2'd2 && t3) begin oc_o = OC_TRAP; trap_el_o = 2'd3; end
      else                        oc_o = OC_EL1;
    end
  end
endmodule

// File: rtl/sra_store.sv
module sra_store
  import sra_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i & KEEP_MASK;
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  a_r9_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i & KEEP_MASK));
endmodule

// File: rtl/sysreg_access_router.sv
module sysreg_access_router
  import sra_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    op0_i,
  input  logic [2:0]    op1_i,
  input  logic [3:0]    crn_i,
  input  logic [3:0]    crm_i,
  input  logic [2:0]    op2_i,
  input  logic          wr_i,
  input  logic [63:0]   wdata_i,
  input  logic [1:0]    cur_el_i,
  input  logic          el2_en_i,
  input  logic          el3_has_i,
  input  logic          el2_a32_i,
  input  logic          el3_a32_i,
  input  logic          el2_trap_i,
  input  logic          el3_trap_i,
  input  logic [2:0]    nv_ctrl_i,
  input  logic          host_ext_i,
  output logic          valid_o,
  output logic          acc_el1_o,
  output logic          acc_el2_o,
  output logic          mem_redir_o,
  output logic          trap_o,
  output logic          undef_o,
  output logic [1:0]    trap_el_o,
  output logic [5:0]    syndrome_o,
  output logic [11:0]   mem_off_o,
  output logic [63:0]   rdata_o
);
  logic          hit, go, we;
  oc_e           oc;
  logic [1:0]    tel;
  logic [DW-1:0] q;

  sra_decode u_dec (
    .op0_i, .op1_i, .crn_i, .crm_i, .op2_i, .cur_el_i,
    .el2_en_i, .el3_has_i, .el2_a32_i, .el3_a32_i,
    .el2_trap_i, .el3_trap_i, .nv_ctrl_i, .host_ext_i,
    .hit_o(hit), .oc_o(oc), .trap_el_o(tel)
  );

  assign go = req_i && hit;
  assign we = go && wr_i && (oc == OC_EL1);

  sra_store u_st (
    .clk_i, .rst_ni, .we_i(we), .wdata_i, .q_o(q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; acc_el1_o <= 1'b0; acc_el2_o <= 1'b0;
      mem_redir_o <= 1'b0; trap_o <= 1'b0; undef_o <= 1'b0;
      trap_el_o <= '0; syndrome_o <= '0; mem_off_o <= '0; rdata_o <= '0;
    end else begin
      valid_o     <= go;
      acc_el1_o   <= go && (oc == OC_EL1);
      acc_el2_o   <= go && (oc == OC_EL2);
      mem_redir_o <= go && (oc == OC_MEM);
      trap_o      <= go && (oc == OC_TRAP);
      undef_o     <= go && (oc == OC_UNDEF);
      trap_el_o   <= (go && oc == OC_TRAP) ? tel : 2'd0;
      syndrome_o  <= (go && oc == OC_TRAP) ? SYN_CLASS : 6'd0;
      mem_off_o   <= (go && oc == OC_MEM) ? MEM_OFF : 12'd0;
      rdata_o     <= (go && !wr_i && oc == OC_EL1) ? (q & KEEP_MASK) : '0;
    end
  end

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot({acc_el1_o, acc_el2_o, mem_redir_o, trap_o, undef_o}));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(acc_el1_o || acc_el2_o || mem_redir_o || trap_o || undef_o));
  a_r2_el0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && cur_el_i == 2'd0) |=> undef_o);
  a_r1_nohit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit) |=> !valid_o);
  a_r8_trap_info: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (syndrome_o == 6'h18 && trap_el_o >= 2'd2));
  a_r8_redir_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_redir_o |-> mem_off_o == 12'h880);
  a_r5_el3_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && cur_el_i == 2'd3 && op1_i == 3'b000) |=> acc_el1_o);
endmodule

// File: tb/tb_sysreg_access_router.sv
module tb_sysreg_access_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0;
  logic [1:0] op0 = 0, el = 0;
  logic [2:0] op1 = 0, op2 = 0, nv = 0;
  logic [3:0] crn = 0, crm = 0;
  logic [63:0] wd = 0;
  logic e2en = 0, e3has = 0, e2a32 = 0, e3a32 = 0, e2t = 0, e3t = 0, hx = 0;
  logic vld, a1, a2, mr, tr, ud;
  logic [1:0] tel;
  logic [5:0] syn;
  logic [11:0] moff;
  logic [63:0] rd;

  int n_run = 0, n_fail = 0;
  logic [63:0] model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_access_router dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op0_i(op0), .op1_i(op1),
    .crn_i(crn), .crm_i(crm), .op2_i(op2), .wr_i(wr), .wdata_i(wd),
    .cur_el_i(el), .el2_en_i(e2en), .el3_has_i(e3has), .el2_a32_i(e2a32),
    .el3_a32_i(e3a32), .el2_trap_i(e2t), .el3_trap_i(e3t), .nv_ctrl_i(nv),
    .host_ext_i(hx), .valid_o(vld), .acc_el1_o(a1), .acc_el2_o(a2),
    .mem_redir_o(mr), .trap_o(tr), .undef_o(ud), .trap_el_o(tel),
    .syndrome_o(syn), .mem_off_o(moff), .rdata_o(rd)
  );

  // codes: -1 none, 0 el1, 1 el2, 2 mem, 3 trap to 2, 4 trap to 3, 5 undef
  function automatic int expect_code();
    bit base = (op0 == 2'b11) && (crn == 4'b0001) && (crm == 4'b0010) && (op2 == 3'b001);
    bit pri = base && op1 == 3'b000;
    bit ali = base && op1 == 3'b101;
    bit l2trap = e2en && !e2a32 && e2t;
    bit l3trap = e3has && !e3a32 && e3t;
    if (!pri && !ali) return -1;
    if (el == 0) return 5;
    if (pri) begin
      if (el == 3) return 0;
      if (el == 2) return l3trap ? 4 : (hx ? 1 : 0);
      if (l2trap) return 3;
      if (l3trap) return 4;
      if (e2en && !e2a32 && nv == 3'b111) return 2;
      return 0;
    end
    if (el == 1) begin
      if (e2en && nv == 3'b101) return 2;
      if (e2en && nv[0]) return 3;
      return 5;
    end
    if (!(e2en && hx)) return 5;
    if (el == 2 && l3trap) return 4;
    return 0;
  endfunction

  function automatic string tag_of();
    if (!((op0 == 2'b11) && (crn == 4'b0001) && (crm == 4'b0010) && (op2 == 3'b001)
          && (op1 == 3'b000 || op1 == 3'b101))) return "R1";
    if (el == 0) return "R2";
    if (op1 == 3'b000) return (el == 1) ? "R3" : (el == 2) ? "R4" : "R5";
    return (el == 1) ? "R6" : "R7";
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_enc(bit alias_enc);
    op0 = 2'b11; op1 = alias_enc ? 3'b101 : 3'b000;
    crn = 4'b0001; crm = 4'b0010; op2 = 3'b001;
  endtask

  task automatic issue();
    int code;
    bit isrd;
    logic [4:0] exp_oh;
    code = expect_code();
    isrd = !wr;
    @(negedge clk);
    req = 1;
    @(negedge clk);
    req = 0;
    if (code < 0) begin
      chk(!vld, "R1", {127'd0, vld}, 128'd0);
    end else begin
      exp_oh = 5'b0;
      case (code)
        0: exp_oh = 5'b10000; 1: exp_oh = 5'b01000; 2: exp_oh = 5'b00100;
        3, 4: exp_oh = 5'b00010; default: exp_oh = 5'b00001;
      endcase
      chk(vld && {a1, a2, mr, tr, ud} == exp_oh, {tag_of(), "/R10"},
          {122'd0, vld, a1, a2, mr, tr, ud}, {122'd0, 1'b1, exp_oh});
      if (code == 3 || code == 4)
        chk(syn == 6'h18 && tel == ((code == 3) ? 2'd2 : 2'd3), "R8",
            {120'd0, tel, syn}, {120'd0, (code == 3) ? 2'd2 : 2'd3, 6'h18});
      if (code == 2)
        chk(moff == 12'h880, "R8", {116'd0, moff}, {116'd0, 12'h880});
      if (code == 0 && isrd)
        chk(rd == model, "R9", {64'd0, rd}, {64'd0, model});
      else
        chk(rd == 0, "R9", {64'd0, rd}, 128'd0);
      if (code == 0 && !isrd) model = wd & 64'h63;
    end
  endtask

  task automatic clr_ctl();
    e2en = 0; e3has = 0; e2a32 = 0; e3a32 = 0; e2t = 0; e3t = 0; nv = 0; hx = 0;
  endtask

  task automatic rd_el3();
    clr_ctl(); set_enc(0); el = 3; wr = 0; issue();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!vld && rd == 0, "R10", {63'd0, vld, rd}, 128'd0);
    rst_n = 1;

    rd_el3(); // R9 reset value zero
    // R9 masked write then read back
    clr_ctl(); set_enc(0); el = 3; wr = 1; wd = 64'hFFFF_FFFF_FFFF_FFFF; issue();
    rd_el3();
    wd = 64'hAAAA_AAAA_AAAA_AAA9; wr = 1; issue();
    rd_el3();

    // R3 chain positions
    clr_ctl(); set_enc(0); el = 1; wr = 1; wd = 64'h22;
    e2en = 1; e2t = 1; e3has = 1; e3t = 1; nv = 3'b111; issue();
    e2t = 0; issue();
    e3t = 0; issue();
    nv = 3'b110; issue();
    rd_el3();
    e2en = 1; e2a32 = 1; e2t = 1; nv = 3'b111; el = 1; wr = 0; set_enc(0); issue();
    // R4
    clr_ctl(); set_enc(0); el = 2; wr = 1; wd = 64'h41;
    e3has = 1; e3t = 1; issue();
    e3a32 = 1; hx = 1; issue();
    hx = 0; issue();
    rd_el3();
    // R6
    clr_ctl(); set_enc(1); el = 1; wr = 1; wd = 64'h3;
    e2en = 1; nv = 3'b101; issue();
    nv = 3'b111; issue();
    nv = 3'b100; issue();
    e2en = 0; nv = 3'b101; issue();
    rd_el3();
    // R7
    clr_ctl(); set_enc(1); el = 2; wr = 1; wd = 64'h60;
    e2en = 1; hx = 1; e3has = 1; e3t = 1; issue();
    e3t = 0; issue();
    el = 3; e3t = 1; wr = 0; issue();
    hx = 0; issue();
    el = 2; issue();
    // R2
    el = 0; set_enc(0); e2en = 1; hx = 1; issue();
    set_enc(1); issue();
    // R1 near-miss encodings
    set_enc(0); el = 3; crm = 4'b0011; issue();
    set_enc(0); op1 = 3'b001; issue();
    rd_el3();

    for (int i = 0; i < 600; i++) begin
      int pick = $urandom_range(0, 9);
      if (pick < 5) set_enc(0);
      else if (pick < 9) set_enc(1);
      else begin
        op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
        crm = 4'($urandom); op2 = 3'($urandom);
      end
      el = 2'($urandom);
      wr = 1'($urandom);
      wd = {$urandom, $urandom};
      e2en  = ($urandom_range(0, 3) != 0);
      e3has = ($urandom_range(0, 3) != 0);
      e2a32 = ($urandom_range(0, 4) == 0);
      e3a32 = ($urandom_range(0, 4) == 0);
      e2t = ($urandom_range(0, 2) == 0);
      e3t = ($urandom_range(0, 2) == 0);
      nv = ($urandom_range(0, 2) == 0) ? 3'b111 :
           ($urandom_range(0, 1) == 0) ? 3'b101 : 3'($urandom);
      hx = 1'($urandom);
      issue();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule